// File: doc/BRIEF.md
# Segment Address Translator

This unit turns a two-part logical address, a segment number and an offset, into a physical address. The segment descriptors sit in a table in ordinary memory. A table base register gives the table's start, and a table length register gives how many segments the table holds. Software sets both registers through two write ports.

A CPU request carries a segment number, an offset and an access kind (read, write or execute). The unit handles one request at a time.

- **Segment out of range:** the unit answers with a trap at once and makes no memory access.
- **Segment in range:** the unit issues one 64-bit read for the descriptor. It then checks the descriptor's validity, its limit and its permissions, in that order. It answers either with base plus offset or with the cause of the first check that failed.

The memory port has a request strobe with an address. Memory answers with a data strobe any number of cycles later. Each response is a one-cycle pulse that carries either a physical address or a trap cause.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` and `mem_rd_req` are 0. Both table registers reset to 0, so a request made before any length write traps as out of range.
- R2: A request whose segment number is not below the table length gets a response in the cycle after acceptance, with cause 1 (range), `rsp_paddr` 0 and no memory read.
- R3: A request with a legal segment number makes exactly one memory read. The read address is table base + segment × 8, modulo 2^32.
- R4: Descriptor layout: base in bits [31:0], limit in bits [51:32], permissions R/W/X in bits [62:60], valid bit in bit 63, reserved bits [59:52]. A descriptor with bit 63 clear, or with any reserved bit set, gives cause 2 (invalid).
- R5: An offset greater than or equal to the descriptor limit gives cause 3 (limit).
- R6: Access kind 0 (read) needs bit 62, kind 1 (write) needs bit 61 and kind 2 (execute) needs bit 60. Kind 3 is never permitted. A denied access gives cause 4 (privilege).
- R7: A request that passes every check gets cause 0 and `rsp_paddr` = base + zero-extended offset, modulo 2^32. Every trap response carries `rsp_paddr` 0.
- R8: When several checks fail, the cause reported is the first failure in the order range, invalid, limit, privilege.
- R9: `req_ready` is 0 from acceptance until the response cycle. `rsp_valid` is high for exactly one cycle per request. The memory response is taken only while the unit waits for it.
- R10: A table base or length write takes effect for every request accepted after the write's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_base_we | input | 1 | Write strobe for the table base register |
| cfg_base_wdata | input | 32 | New table base |
| cfg_len_we | input | 1 | Write strobe for the table length register |
| cfg_len_wdata | input | SEG_W+1 | New table length (number of segments) |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit idle; a request is accepted when both are high |
| req_seg | input | SEG_W | Segment number |
| req_off | input | 20 | Offset within the segment |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| mem_rd_req | output | 1 | One-cycle descriptor read strobe |
| mem_rd_addr | output | 32 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Descriptor data present |
| mem_rsp_data | input | 64 | Descriptor contents |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_cause | output | 3 | 0 none, 1 range, 2 invalid, 3 limit, 4 privilege |
| rsp_paddr | output | 32 | Physical address, 0 on a trap |

## Verification
A wrong held offset, access kind or descriptor address shows up in the response to that same request: a wrong physical address, a wrong cause, or a read at an unexpected address. The bench sees it within a few cycles of the memory answer. A wrong sequencer state shows up as a response that comes early, comes twice or never comes. It can also show up as a read made for an out-of-range segment, or as `req_ready` rising while a read is outstanding. The bench compares every response and every read against a model computed from the table it serves. It drives random segments, lengths, latencies and descriptors, plus directed cases where several checks fail at once.

// File: rtl/seg_xlate_pkg.sv
// Shared definitions for the segment translator.
// Holds the descriptor field positions, the access kinds and the trap causes.
// Assumes a 32-bit physical address and a 64-bit descriptor.
package seg_xlate_pkg;
    localparam int BASE_W   = 32;
    localparam int ENT_W    = 64;
    localparam int LIM_LSB  = 32;
    localparam int LIM_W    = 20;
    localparam int RSV_LSB  = LIM_LSB + LIM_W;
    localparam int RSV_W    = 8;
    localparam int PERM_LSB = RSV_LSB + RSV_W;
    localparam int PERM_W   = 3;
    localparam int VLD_BIT  = PERM_LSB + PERM_W;
    localparam int ENT_SHIFT = 3;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        TRAP_NONE    = 3'd0,
        TRAP_RANGE   = 3'd1,
        TRAP_INVALID = 3'd2,
        TRAP_LIMIT   = 3'd3,
        TRAP_PRIV    = 3'd4
    } trap_e;
endpackage

// File: rtl/seg_xlate_regs.sv
// Table base and table length registers.
// Each register loads on its own write strobe and resets to zero.
// Assumes a single writer, so no arbitration is needed.
module seg_xlate_regs
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_we,
    input  logic [BASE_W-1:0] base_wdata,
    input  logic             len_we,
    input  logic [SEG_W:0]   len_wdata,
    output logic [BASE_W-1:0] tbl_base,
    output logic [SEG_W:0]   tbl_len
);
    // Load the table base register.
    always_ff @(posedge clk) begin
        if (!rst_n)       tbl_base <= '0;
        else if (base_we) tbl_base <= base_wdata;
    end

    // Load the table length register.
    always_ff @(posedge clk) begin
        if (!rst_n)      tbl_len <= '0;
        else if (len_we) tbl_len <= len_wdata;
    end
endmodule

// File: rtl/seg_xlate_check.sv
// Descriptor checker, purely combinational.
// Decodes a fetched descriptor and applies the validity, limit and
// permission checks in that order. The first failure sets the cause.
// On success it forms base plus offset. Assumes the range check was
// already done by the sequencer.
module seg_xlate_check
    import seg_xlate_pkg::*;
(
    input  logic [ENT_W-1:0]  ent,
    input  logic [LIM_W-1:0]  off,
    input  logic [1:0]        acc,
    output logic [2:0]        cause,
    output logic [BASE_W-1:0] paddr
);
    logic [BASE_W-1:0] f_base;
    logic [LIM_W-1:0]  f_lim;
    logic [RSV_W-1:0]  f_rsv;
    logic [PERM_W-1:0] f_perm;
    logic              f_vld;
    logic [PERM_W-1:0] grant;
    logic              allowed;

    assign f_base = ent[BASE_W-1:0];
    assign f_lim  = ent[LIM_LSB +: LIM_W];
    assign f_rsv  = ent[RSV_LSB +: RSV_W];
    assign f_perm = ent[PERM_LSB +: PERM_W];
    assign f_vld  = ent[VLD_BIT];

    // Access kind g is granted by permission bit PERM_W-1-g (R, W, X from the top).
    for (genvar g = 0; g < PERM_W; g++) begin : g_grant
        assign grant[g] = (acc == 2'(g)) && f_perm[PERM_W-1-g];
    end
    assign allowed = |grant;

    // Apply the checks in priority order and form the result.
    always_comb begin
        if (!f_vld || (f_rsv != '0)) cause = TRAP_INVALID;
        else if (off >= f_lim)       cause = TRAP_LIMIT;
        else if (!allowed)           cause = TRAP_PRIV;
        else                         cause = TRAP_NONE;
        paddr = (cause == TRAP_NONE) ? (f_base + BASE_W'(off)) : '0;
    end
endmodule

// File: rtl/seg_xlate_ctrl.sv
// Request sequencer.
// Accepts one request when idle and does the range check against the
// length register. Out-of-range requests get an immediate trap. In-range
// requests issue a descriptor read, wait for memory, then register the
// checker's verdict as a one-cycle response. Assumes memory answers only
// after it has seen the read strobe.
module seg_xlate_ctrl
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BASE_W-1:0] tbl_base,
    input  logic [SEG_W:0]    tbl_len,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [LIM_W-1:0]  req_off,
    input  logic [1:0]        req_acc,
    output logic              mem_rd_req,
    output logic [BASE_W-1:0] mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [2:0]        chk_cause,
    input  logic [BASE_W-1:0] chk_paddr,
    output logic [LIM_W-1:0]  held_off,
    output logic [1:0]        held_acc,
    output logic              rsp_valid,
    output logic [2:0]        rsp_cause,
    output logic [BASE_W-1:0] rsp_paddr
);
    typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WAIT} state_e;
    state_e state_q;

    logic accept;
    logic out_of_range;

    assign accept       = (state_q == ST_IDLE) && req_valid;
    assign out_of_range = ({1'b0, req_seg} >= tbl_len);
    assign req_ready    = (state_q == ST_IDLE);
    assign mem_rd_req   = (state_q == ST_READ);

    // Sequence a request from acceptance through read to response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            rsp_valid   <= 1'b0;
            rsp_cause   <= TRAP_NONE;
            rsp_paddr   <= '0;
            mem_rd_addr <= '0;
            held_off    <= '0;
            held_acc    <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        held_off <= req_off;
                        held_acc <= req_acc;
                        if (out_of_range) begin
                            rsp_valid <= 1'b1;
                            rsp_cause <= TRAP_RANGE;
                            rsp_paddr <= '0;
                        end else begin
                            mem_rd_addr <= tbl_base + (BASE_W'(req_seg) << ENT_SHIFT);
                            state_q     <= ST_READ;
                        end
                    end
                end
                ST_READ: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        rsp_valid <= 1'b1;
                        rsp_cause <= chk_cause;
                        rsp_paddr <= chk_paddr;
                        state_q   <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_RANGE_TRAP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && ({1'b0, req_seg} >= tbl_len)) |=> (rsp_valid && rsp_cause == TRAP_RANGE)); // R2
    AST_RANGE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && ({1'b0, req_seg} >= tbl_len)) |=> !mem_rd_req); // R2
    AST_READ_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_req) |-> $past(req_valid && req_ready)); // R3
    AST_TRAP_ZERO_PADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_cause != TRAP_NONE) |-> (rsp_paddr == '0)); // R7
    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R9
    AST_LATE_NOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && mem_rsp_valid) |-> (chk_cause != TRAP_RANGE)); // R8
endmodule

// File: rtl/seg_xlate_unit.sv
// Segment address translator top.
// Connects the table registers, the request sequencer and the descriptor
// checker. One translation is in flight at a time, and descriptors are
// never cached.
module seg_xlate_unit
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_base_we,
    input  logic [BASE_W-1:0] cfg_base_wdata,
    input  logic              cfg_len_we,
    input  logic [SEG_W:0]    cfg_len_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [LIM_W-1:0]  req_off,
    input  logic [1:0]        req_acc,
    output logic              mem_rd_req,
    output logic [BASE_W-1:0] mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [ENT_W-1:0]  mem_rsp_data,
    output logic              rsp_valid,
    output logic [2:0]        rsp_cause,
    output logic [BASE_W-1:0] rsp_paddr
);
    logic [BASE_W-1:0] tbl_base;
    logic [SEG_W:0]    tbl_len;
    logic [LIM_W-1:0]  held_off;
    logic [1:0]        held_acc;
    logic [2:0]        chk_cause;
    logic [BASE_W-1:0] chk_paddr;

    seg_xlate_regs #(.SEG_W(SEG_W)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_we    (cfg_base_we),
        .base_wdata (cfg_base_wdata),
        .len_we     (cfg_len_we),
        .len_wdata  (cfg_len_wdata),
        .tbl_base   (tbl_base),
        .tbl_len    (tbl_len)
    );

    seg_xlate_ctrl #(.SEG_W(SEG_W)) i_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .tbl_base      (tbl_base),
        .tbl_len       (tbl_len),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_seg       (req_seg),
        .req_off       (req_off),
        .req_acc       (req_acc),
        .mem_rd_req    (mem_rd_req),
        .mem_rd_addr   (mem_rd_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .chk_cause     (chk_cause),
        .chk_paddr     (chk_paddr),
        .held_off      (held_off),
        .held_acc      (held_acc),
        .rsp_valid     (rsp_valid),
        .rsp_cause     (rsp_cause),
        .rsp_paddr     (rsp_paddr)
    );

    seg_xlate_check i_check (
        .ent   (mem_rsp_data),
        .off   (held_off),
        .acc   (held_acc),
        .cause (chk_cause),
        .paddr (chk_paddr)
    );
endmodule

// File: tb/test_seg_xlate_unit.sv
// Bench for the segment translator: directed corner cases plus seeded random traffic.
module test_seg_xlate_unit;
    localparam int SEG_W = 8;
    localparam int NSEG = 1 << SEG_W;
    localparam int CLK_PERIOD = 10;

    logic clk, rst_n;
    logic cfg_base_we, cfg_len_we;
    logic [31:0] cfg_base_wdata;
    logic [SEG_W:0] cfg_len_wdata;
    logic req_valid, req_ready;
    logic [SEG_W-1:0] req_seg;
    logic [19:0] req_off;
    logic [1:0] req_acc;
    logic mem_rd_req, mem_rsp_valid;
    logic [31:0] mem_rd_addr;
    logic [63:0] mem_rsp_data;
    logic rsp_valid;
    logic [2:0] rsp_cause;
    logic [31:0] rsp_paddr;

    logic [63:0] tab [NSEG];
    logic [31:0] tb_base;
    logic [SEG_W:0] tb_len;
    int checks = 0;
    int fails = 0;

    seg_xlate_unit #(.SEG_W(SEG_W)) i_seg_xlate_unit (
        .clk(clk), .rst_n(rst_n),
        .cfg_base_we(cfg_base_we), .cfg_base_wdata(cfg_base_wdata),
        .cfg_len_we(cfg_len_we), .cfg_len_wdata(cfg_len_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_seg(req_seg),
        .req_off(req_off), .req_acc(req_acc),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R9 watchdog: actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input bit vld, input logic [2:0] perm,
                                       input logic [19:0] lim, input logic [31:0] base);
        return {vld, perm, 8'h00, lim, base};
    endfunction

    function automatic logic [63:0] lookup(input logic [31:0] addr);
        logic [31:0] diff;
        diff = addr - tb_base;
        if ((diff >> 3) < NSEG) return tab[diff[SEG_W+2:3]];
        return 64'h0;
    endfunction

    // Expected {cause, paddr} from the requirements.
    function automatic logic [34:0] model(input logic [SEG_W-1:0] seg,
                                          input logic [19:0] off, input logic [1:0] acc);
        logic [63:0] e;
        logic ok;
        if ({1'b0, seg} >= tb_len) return {3'd1, 32'h0};
        e = tab[seg];
        if (!e[63] || e[59:52] != 8'h0) return {3'd2, 32'h0};
        if (off >= e[51:32]) return {3'd3, 32'h0};
        case (acc)
            2'd0: ok = e[62];
            2'd1: ok = e[61];
            2'd2: ok = e[60];
            default: ok = 1'b0;
        endcase
        if (!ok) return {3'd4, 32'h0};
        return {3'd0, e[31:0] + {12'h0, off}};
    endfunction

    function automatic string tag_of(input logic [2:0] c);
        case (c)
            3'd1: return "R2";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic set_base(input logic [31:0] v);
        @(negedge clk);
        cfg_base_we = 1'b1; cfg_base_wdata = v;
        @(negedge clk);
        cfg_base_we = 1'b0;
        tb_base = v;
    endtask

    task automatic set_len(input logic [SEG_W:0] v);
        @(negedge clk);
        cfg_len_we = 1'b1; cfg_len_wdata = v;
        @(negedge clk);
        cfg_len_we = 1'b0;
        tb_len = v;
    endtask

    task automatic xact(input logic [SEG_W-1:0] seg, input logic [19:0] off,
                        input logic [1:0] acc, input int lat, input string tag);
        logic [34:0] exp;
        bit legal, got;
        int nreads, first_n;
        logic [31:0] raddr;
        string t;
        exp = model(seg, off, acc);
        legal = ({1'b0, seg} < tb_len);
        t = (tag == "") ? tag_of(exp[34:32]) : tag;
        nreads = 0; got = 0; first_n = -1; raddr = '0;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R9", "no response before request", rsp_valid, 0);
        chk(req_ready == 1'b1, "R9", "ready when idle", req_ready, 1);
        req_valid = 1'b1; req_seg = seg; req_off = off; req_acc = acc;
        @(negedge clk);
        req_valid = 1'b0;
        for (int n = 0; n < 40; n++) begin
            if (rsp_valid) begin got = 1; first_n = n; break; end
            if (mem_rd_req) begin
                nreads++;
                raddr = mem_rd_addr;
                chk(req_ready == 1'b0, "R9", "not ready while reading", req_ready, 0);
                repeat (lat) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data = lookup(raddr);
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
        chk(got, "R9", "response arrived", got, 1);
        chk(rsp_cause == exp[34:32], t, "cause", rsp_cause, exp[34:32]);
        chk(rsp_paddr == exp[31:0], t, "paddr", rsp_paddr, exp[31:0]);
        if (legal) begin
            chk(nreads == 1, "R3", "one descriptor read", nreads, 1);
            chk(raddr == tb_base + {21'h0, seg, 3'b000}, "R3", "read address",
                raddr, tb_base + {21'h0, seg, 3'b000});
        end else begin
            chk(nreads == 0, "R2", "no read when out of range", nreads, 0);
            chk(first_n == 0, "R2", "trap cycle after acceptance", first_n, 0);
        end
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5EED_0042);
        rst_n = 1'b0;
        cfg_base_we = 0; cfg_len_we = 0; cfg_base_wdata = 0; cfg_len_wdata = 0;
        req_valid = 0; req_seg = 0; req_off = 0; req_acc = 0;
        mem_rsp_valid = 0; mem_rsp_data = 0;
        tb_base = 0; tb_len = 0;
        for (int i = 0; i < NSEG; i++) begin
            logic [63:0] r;
            r = {$urandom, $urandom};
            if ($urandom % 8 != 0) r[59:52] = 8'h0;
            if ($urandom % 5 != 0) r[63] = 1'b1;
            tab[i] = r;
        end
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1", "no response after reset", rsp_valid, 0);
        chk(mem_rd_req == 1'b0, "R1", "no read after reset", mem_rd_req, 0);
        rst_n = 1'b1;

        xact(8'd0, 20'd0, 2'd0, 1, "R1");

        set_base(32'h0000_1000);
        set_len(9'd4);
        tab[0] = mk(1, 3'b111, 20'h100, 32'h8000_0000);
        xact(8'd0, 20'h0FF, 2'd0, 1, "R7");
        xact(8'd0, 20'h100, 2'd0, 2, "R5");
        tab[3] = mk(1, 3'b100, 20'hFFFFF, 32'hFFFF_FFF0);
        xact(8'd3, 20'h20, 2'd0, 3, "R7");
        xact(8'd3, 20'h5, 2'd1, 1, "R6");
        xact(8'd3, 20'h5, 2'd2, 1, "R6");
        xact(8'd3, 20'h5, 2'd3, 1, "R6");
        xact(8'd4, 20'h0, 2'd0, 1, "R2");
        xact(8'd255, 20'h0, 2'd0, 1, "R2");
        tab[1] = mk(0, 3'b000, 20'h10, 32'h1234);
        xact(8'd1, 20'h20, 2'd1, 1, "R8");
        tab[2] = mk(1, 3'b000, 20'h10, 32'h5000);
        xact(8'd2, 20'h20, 2'd2, 2, "R8");
        tab[2] = mk(1, 3'b010, 20'h10, 32'h5000);
        xact(8'd2, 20'h4, 2'd0, 1, "R8");
        xact(8'd2, 20'h4, 2'd1, 1, "R7");
        tab[1] = {1'b1, 3'b111, 8'h01, 20'hFFFFF, 32'h0};
        xact(8'd1, 20'h1, 2'd0, 1, "R4");
        set_len(9'd0);
        xact(8'd0, 20'h0, 2'd0, 1, "R10");
        set_base(32'hFFFF_FFF8);
        set_len(9'd256);
        tab[255] = mk(1, 3'b001, 20'h40, 32'h0002_0000);
        xact(8'd255, 20'h3F, 2'd2, 1, "R10");

        for (int k = 0; k < 300; k++) begin
            logic [SEG_W-1:0] s;
            logic [19:0] o;
            if ($urandom % 16 == 0) set_base($urandom);
            if ($urandom % 12 == 0) set_len(9'($urandom % (NSEG + 1)));
            s = SEG_W'($urandom);
            if ($urandom % 4 != 0) o = 20'($urandom % ({12'h0, tab[s][51:32]} + 1));
            else o = 20'($urandom);
            xact(s, o, 2'($urandom), 1 + int'($urandom % 3), "");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule